// File: doc/BRIEF.md
# Static LCD Segment and Backplane Driver

This block drives a three-and-a-half digit static liquid-crystal display from a stored reading. It holds three BCD digits (units, tens, hundreds), a flag that lights the leading "1", and a flag that lights the minus sign. A free-running divider turns the oscillator clock into a square-wave backplane signal. Every segment pin carries that same waveform. It is passed through unchanged when the segment is dark and inverted when the segment is lit, so no segment ever sees a DC voltage across it.

A new reading enters through a valid/ready load port. `load_ready` is always high, so the block never applies back-pressure. The reading is captured whole on any rising clock edge where `load_valid` is high. When `load_valid` is low, the digit and flag inputs are ignored. A lamp-test input lights all 23 segment outputs at once, which shows -1888, for as long as it is held. It does not change the stored reading.

Top module: `lcd_static_driver`

## Requirements
- R1: While reset is active and in the first cycle after it, `bp_out` is 0 and every segment output is 0. The stored reading resets to blank digits (code 15) with both flags clear.
- R2: `bp_out` toggles once every DIV_HALF clock cycles (default 400). Its period is 2*DIV_HALF cycles with a 50% duty cycle.
- R3: In every cycle, a dark segment output equals `bp_out` and a lit segment output equals the inverse of `bp_out`, with no cycle of offset between them.
- R4: Each full-digit bus is ordered bit0=a, bit1=b, bit2=c, bit3=d, bit4=e, bit5=f, bit6=g. The lit sets for codes 0..9 are 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F.
- R5: A stored BCD code from 10 to 15 leaves all seven segments of that digit dark.
- R6: `thou_seg` is lit exactly when the stored thousands flag is 1.
- R7: `sign_seg` is lit exactly when the stored negative flag is 1.
- R8: `load_ready` is always 1. Inputs are captured only on a rising edge with `load_valid` high. Input changes without `load_valid` have no effect on any output.
- R9: While `lamp_test` is 1, all 23 segment outputs are lit in the same cycle. When it is released, the display returns to the stored reading.
- R10: A single load replaces every stored digit and flag at once. All changed outputs switch in the same cycle, the one right after the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Capture the reading inputs on this edge |
| load_ready | output | 1 | Always 1 |
| units_bcd | input | 4 | Units digit, BCD |
| tens_bcd | input | 4 | Tens digit, BCD |
| hundreds_bcd | input | 4 | Hundreds digit, BCD |
| thousand_on | input | 1 | Light the leading "1" |
| negative | input | 1 | Light the minus sign |
| lamp_test | input | 1 | Force every segment lit |
| bp_out | output | 1 | Backplane square wave |
| units_seg | output | 7 | Units segments a..g (bit0=a) |
| tens_seg | output | 7 | Tens segments a..g (bit0=a) |
| hund_seg | output | 7 | Hundreds segments a..g (bit0=a) |
| thou_seg | output | 1 | Both halves of the leading "1" |
| sign_seg | output | 1 | Minus sign |

## Verification
The bench walks every code from 0 to 15 through each digit position and compares all outputs against a reference model on every clock. A wrong decode entry would show up as a mismatched segment in one phase, and a missing blanking rule would show garbage for codes above 9. It changes the inputs without `load_valid` and expects no change. A latch that follows its inputs would instead show the new value at once. It measures the spacing of backplane edges, which catches an off-by-one divider as a period of 798 or 802 cycles. It also applies lamp test in both backplane phases, where a design that registers the override, or that overwrites the stored reading with it, would miss a cycle or fail to restore the display.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

  localparam int SEG_W  = 7;
  localparam int N_FULL = 3;
  localparam int N_OUT  = N_FULL * SEG_W + 2;

  typedef logic [SEG_W-1:0] seg7_t;

  typedef struct packed {
    logic [3:0] hund;
    logic [3:0] tens;
    logic [3:0] units;
    logic       thou;
    logic       neg;
  } reading_t;

  localparam reading_t READING_BLANK = '{hund: 4'hF, tens: 4'hF, units: 4'hF,
                                          thou: 1'b0, neg: 1'b0};

  // bit0 = a ... bit6 = g; codes above 9 give a dark digit
  function automatic seg7_t bcd_to_seg(input logic [3:0] code);
    seg7_t s;
    case (code)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lcd_bp_divider.sv
module lcd_bp_divider #(
  parameter int DIV_HALF = 400
) (
  input  logic clk,
  input  logic rst_n,
  output logic bp
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      bp  <= 1'b0;
    end else if (cnt == LAST) begin
      cnt <= '0;
      bp  <= ~bp;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_reading_latch.sv
module lcd_reading_latch
  import lcd_drv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  reading_t rd_in,
  output reading_t rd_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    rd_q <= READING_BLANK;
    else if (load) rd_q <= rd_in;
  end
endmodule

// File: rtl/lcd_seg_phase.sv
module lcd_seg_phase #(
  parameter int N = 23
) (
  input  logic         bp,
  input  logic [N-1:0] lit,
  output logic [N-1:0] drive
);
  // lit segments run against the backplane, dark ones with it
  for (genvar i = 0; i < N; i++) begin : g_phase
    assign drive[i] = lit[i] ^ bp;
  end
endmodule

// File: rtl/lcd_static_driver.sv
module lcd_static_driver
  import lcd_drv_pkg::*;
#(
  parameter int DIV_HALF = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_valid,
  output logic       load_ready,
  input  logic [3:0] units_bcd,
  input  logic [3:0] tens_bcd,
  input  logic [3:0] hundreds_bcd,
  input  logic       thousand_on,
  input  logic       negative,
  input  logic       lamp_test,
  output logic       bp_out,
  output logic [6:0] units_seg,
  output logic [6:0] tens_seg,
  output logic [6:0] hund_seg,
  output logic       thou_seg,
  output logic       sign_seg
);
  reading_t         rd_in, rd_q;
  logic [3:0]       digit [N_FULL];
  logic [N_OUT-1:0] lit_dec, lit, drive;
  logic             bp;

  assign load_ready = 1'b1;
  assign rd_in = '{hund: hundreds_bcd, tens: tens_bcd, units: units_bcd,
                   thou: thousand_on, neg: negative};

  lcd_reading_latch u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_valid),
    .rd_in (rd_in),
    .rd_q  (rd_q)
  );

  lcd_bp_divider #(.DIV_HALF(DIV_HALF)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .bp    (bp)
  );

  assign digit[0] = rd_q.units;
  assign digit[1] = rd_q.tens;
  assign digit[2] = rd_q.hund;

  for (genvar d = 0; d < N_FULL; d++) begin : g_dec
    assign lit_dec[d*SEG_W +: SEG_W] = bcd_to_seg(digit[d]);
  end
  assign lit_dec[N_FULL*SEG_W]     = rd_q.thou;
  assign lit_dec[N_FULL*SEG_W + 1] = rd_q.neg;

  assign lit = lamp_test ? {N_OUT{1'b1}} : lit_dec;

  lcd_seg_phase #(.N(N_OUT)) u_phase (
    .bp    (bp),
    .lit   (lit),
    .drive (drive)
  );

  assign bp_out    = bp;
  assign units_seg = drive[0 +: SEG_W];
  assign tens_seg  = drive[SEG_W +: SEG_W];
  assign hund_seg  = drive[2*SEG_W +: SEG_W];
  assign thou_seg  = drive[N_FULL*SEG_W];
  assign sign_seg  = drive[N_FULL*SEG_W + 1];
endmodule

// File: rtl/lcd_static_driver_chk.sv
module lcd_static_driver_chk #(
  parameter int DIV_HALF = 400
) (
  input logic       clk,
  input logic       rst_n,
  input logic       load_valid,
  input logic       load_ready,
  input logic [3:0] units_bcd,
  input logic       thousand_on,
  input logic       negative,
  input logic       lamp_test,
  input logic       bp_out,
  input logic [6:0] units_seg,
  input logic [6:0] tens_seg,
  input logic [6:0] hund_seg,
  input logic       thou_seg,
  input logic       sign_seg
);
  int unsigned run;
  logic        bp_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 0;
      bp_prev <= 1'b0;
    end else begin
      bp_prev <= bp_out;
      run     <= (bp_out != bp_prev) ? 1 : run + 1;
    end
  end

  // R2: edges are exactly DIV_HALF cycles apart
  p_bp_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_out != bp_prev) |-> (run == DIV_HALF))
    else $error("bp spacing");
  p_bp_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run <= DIV_HALF)
    else $error("bp stalled");

  p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n) load_ready)
    else $error("ready low");

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_valid && !lamp_test) |=>
      (lamp_test || bp_out != $past(bp_out) ||
       (units_seg == $past(units_seg) && tens_seg == $past(tens_seg) &&
        hund_seg == $past(hund_seg) && thou_seg == $past(thou_seg) &&
        sign_seg == $past(sign_seg))))
    else $error("display changed without load");

  p_lamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_test |-> (units_seg == {7{~bp_out}} && tens_seg == {7{~bp_out}} &&
                   hund_seg == {7{~bp_out}} && thou_seg == ~bp_out &&
                   sign_seg == ~bp_out))
    else $error("lamp test");

  p_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(load_valid) && !lamp_test) |->
      ((sign_seg ^ bp_out) == $past(negative)))
    else $error("sign");

  p_thou_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(load_valid) && !lamp_test) |->
      ((thou_seg ^ bp_out) == $past(thousand_on)))
    else $error("thousands");

  p_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(load_valid) && $past(units_bcd) > 4'd9 && !lamp_test) |->
      (units_seg == {7{bp_out}}))
    else $error("blank");
endmodule

bind lcd_static_driver lcd_static_driver_chk #(.DIV_HALF(DIV_HALF)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_valid  (load_valid),
  .load_ready  (load_ready),
  .units_bcd   (units_bcd),
  .thousand_on (thousand_on),
  .negative    (negative),
  .lamp_test   (lamp_test),
  .bp_out      (bp_out),
  .units_seg   (units_seg),
  .tens_seg    (tens_seg),
  .hund_seg    (hund_seg),
  .thou_seg    (thou_seg),
  .sign_seg    (sign_seg)
);

// File: tb/tb_lcd_static_driver.sv
`timescale 1ns/1ps
module tb_lcd_static_driver;
  localparam int HALF = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_valid = 1'b0;
  logic [3:0] units_bcd = 0, tens_bcd = 0, hundreds_bcd = 0;
  logic thousand_on = 0, negative = 0, lamp_test = 0;
  logic load_ready, bp_out, thou_seg, sign_seg;
  logic [6:0] units_seg, tens_seg, hund_seg;

  always #2.5 clk = ~clk;

  lcd_static_driver #(.DIV_HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_ready(load_ready),
    .units_bcd(units_bcd), .tens_bcd(tens_bcd), .hundreds_bcd(hundreds_bcd),
    .thousand_on(thousand_on), .negative(negative), .lamp_test(lamp_test),
    .bp_out(bp_out), .units_seg(units_seg), .tens_seg(tens_seg),
    .hund_seg(hund_seg), .thou_seg(thou_seg), .sign_seg(sign_seg));

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference model state
  int m_cnt = 0;
  bit m_bp = 0;
  int m_u = 15, m_t = 15, m_h = 15;
  bit m_th = 0, m_ng = 0;

  function automatic logic [6:0] seg_of(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_bp = 0; m_u = 15; m_t = 15; m_h = 15; m_th = 0; m_ng = 0;
    end else begin
      if (m_cnt == HALF - 1) begin m_cnt = 0; m_bp = ~m_bp; end
      else m_cnt++;
      if (load_valid) begin
        m_u = units_bcd; m_t = tens_bcd; m_h = hundreds_bcd;
        m_th = thousand_on; m_ng = negative;
      end
    end
  end

  // per-cycle comparison against the model
  int cyc = 0, last_edge = -1;
  bit prev_bp = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      logic [6:0] eu, et, eh, inv;
      inv = {7{m_bp}};
      eu = (lamp_test ? 7'h7F : seg_of(m_u)) ^ inv;
      et = (lamp_test ? 7'h7F : seg_of(m_t)) ^ inv;
      eh = (lamp_test ? 7'h7F : seg_of(m_h)) ^ inv;
      chk(bp_out == m_bp, "R2 bp", bp_out, m_bp);
      chk(units_seg == eu, "R4 units", units_seg, eu);
      chk(tens_seg == et, "R4 tens", tens_seg, et);
      chk(hund_seg == eh, "R4 hundreds", hund_seg, eh);
      chk(thou_seg == ((lamp_test | m_th) ^ m_bp), "R6 thousands", thou_seg, (lamp_test | m_th) ^ m_bp);
      chk(sign_seg == ((lamp_test | m_ng) ^ m_bp), "R7 sign", sign_seg, (lamp_test | m_ng) ^ m_bp);
      chk(load_ready == 1'b1, "R8 ready", load_ready, 1);
      if (bp_out != prev_bp) begin
        if (last_edge >= 0) chk(cyc - last_edge == HALF, "R2 period", cyc - last_edge, HALF);
        last_edge = cyc;
      end
      prev_bp = bp_out;
    end
  end

  task automatic load(input int u, input int t, input int h, input bit th, input bit ng);
    @(posedge clk); #1;
    units_bcd = u[3:0]; tens_bcd = t[3:0]; hundreds_bcd = h[3:0];
    thousand_on = th; negative = ng; load_valid = 1;
    @(posedge clk); #1;
    load_valid = 0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(bp_out == 0 && units_seg == 0 && tens_seg == 0 && hund_seg == 0 &&
        thou_seg == 0 && sign_seg == 0, "R1 during reset",
        {bp_out, units_seg, tens_seg, hund_seg, thou_seg, sign_seg}, 0);
    @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    chk(bp_out == 0 && units_seg == 0 && thou_seg == 0 && sign_seg == 0,
        "R1 after reset", {bp_out, units_seg, thou_seg, sign_seg}, 0);

    // R4 / R5: every code through each position
    for (int c = 0; c < 16; c++) begin
      load(c, (c + 3) % 16, (c + 7) % 16, c[0], c[1]);
      @(negedge clk);
      chk(units_seg == (seg_of(c) ^ {7{bp_out}}), "R4 R5 units code", units_seg, seg_of(c) ^ {7{bp_out}});
      if (c > 9) chk((units_seg ^ {7{bp_out}}) == 0, "R5 blank", units_seg ^ {7{bp_out}}, 0);
      wait_cycles(37);
    end

    // R10: all fields change together
    load(1, 2, 3, 0, 0);
    wait_cycles(5);
    load(8, 9, 0, 1, 1);
    @(negedge clk);
    chk((units_seg ^ {7{bp_out}}) == 7'h7F && (tens_seg ^ {7{bp_out}}) == 7'h6F &&
        (hund_seg ^ {7{bp_out}}) == 7'h3F && (thou_seg ^ bp_out) && (sign_seg ^ bp_out),
        "R10 atomic update", {units_seg, tens_seg, hund_seg}, 0);

    // R8: input changes without load have no effect
    @(posedge clk); #1;
    units_bcd = 4; tens_bcd = 4; hundreds_bcd = 4; thousand_on = 0; negative = 0;
    wait_cycles(10);
    @(negedge clk);
    chk((units_seg ^ {7{bp_out}}) == 7'h7F && (sign_seg ^ bp_out) == 1,
        "R8 ignored without load", units_seg ^ {7{bp_out}}, 7'h7F);

    // R3: lit/dark phase in both backplane phases
    load(1, 15, 15, 0, 0);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(units_seg[1] == ~bp_out && units_seg[0] == bp_out, "R3 phase",
          units_seg, {5'b0, ~bp_out, bp_out});
      wait_cycles(HALF);
    end

    // R9: lamp test in both phases, then release
    for (int k = 0; k < 2; k++) begin
      @(posedge clk); #1; lamp_test = 1;
      @(negedge clk);
      chk(units_seg == {7{~bp_out}} && tens_seg == {7{~bp_out}} && hund_seg == {7{~bp_out}} &&
          thou_seg == ~bp_out && sign_seg == ~bp_out, "R9 lamp on",
          {units_seg, tens_seg, hund_seg}, {21{~bp_out}});
      wait_cycles(HALF);
      @(posedge clk); #1; lamp_test = 0;
      @(negedge clk);
      chk((units_seg ^ {7{bp_out}}) == 7'h06 && (tens_seg ^ {7{bp_out}}) == 0,
          "R9 lamp release", units_seg ^ {7{bp_out}}, 7'h06);
    end

    wait_cycles(2 * HALF + 10);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule